// File: doc/BRIEF.md
# Programmable-Mask BAR Register Bank

This block holds the Base Address Registers of one PCIe endpoint function. There are six 32-bit slots. Each slot has a companion mask register loaded with the window size minus one. Address bits set in the mask are held at zero, so the host's usual sizing probe works: it writes all ones, reads the slot back, and the cleared low bits give the window size. A slot whose type field says 64-bit takes the slot after it as its upper half. That upper slot then carries 32 address bits, has no attribute field, and its mask supplies bits 63:32 of the window mask, which allows windows larger than 4 GiB.

The bank has two ports. The host configuration port reads and writes address bits. The local programming port writes attribute nibbles or, with its shadow select raised, mask words. Both ports use the same register offsets. Local writes take effect only while a read-only write-enable input is high. Each BAR also presents its decoded base, size and a valid flag for the address decoder that follows.

Top module: `bar_bank`

## Requirements
- R1: After reset, every slot reads zero and every BAR output is invalid, with base and size zero.
- R2: A local attribute write (shadow select low) stores bits 3:0 of the data only while the write enable is high. At other times it is ignored.
- R3: A local mask write (shadow select high) stores the 32-bit mask only while the write enable is high. At other times it is ignored.
- R4: Host writes change only the address bits that are clear in the slot's mask. Bits 3:0 of a non-upper slot are never host-writable. An all-ones write therefore reads back as (~mask & 0xFFFFFFF0) | attributes.
- R5: The attribute nibble has the following encoding: bit 0 = 1 selects IO space, bits 2:1 = 10 selects 64-bit type, bit 3 marks prefetchable. It reads back exactly as programmed in bits 3:0, and host writes cannot change it.
- R6: A BAR whose mask, the combined 64-bit mask for a pair, is zero is disabled. It reads as zero and its output is invalid, whatever the host writes.
- R7: A slot with type 10 pairs with the next slot. The next slot then reads back its address bits masked only by its own mask, shows no attribute bits, is never valid on its own, and cannot start a pair of its own.
- R8: A 16 GiB prefetchable 64-bit BAR (lower attributes 1100, lower mask 0xFFFFFFFF, upper mask 0x3) answers an all-ones probe with 0x0000000C in the lower slot and 0xFFFFFFFC in the upper slot.
- R9: The last slot set to 64-bit type has no partner. It behaves as a 32-bit BAR whose upper base and mask bits are zero.
- R10: For a valid BAR, base is {upper address bits, lower address bits with bits 3:0 cleared} under the masks, and size is the 64-bit mask plus one, taken modulo 2^64.
- R11: Slot n sits at byte offset BASE_OFS + 4n on both ports. Accesses outside that range read zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | AW | Host byte address |
| cfg_wr | input | 1 | Host write strobe |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data for cfg_addr (combinational) |
| loc_addr | input | AW | Local programming byte address |
| loc_wr | input | 1 | Local write strobe |
| loc_shadow | input | 1 | 1 writes the mask, 0 writes the attribute nibble |
| loc_wdata | input | 32 | Local write data |
| ro_wr_en | input | 1 | Gate for local attribute and mask writes |
| bar_valid | output | NUM_BARS | BAR n is enabled and is not an upper half |
| bar_base | output | 64*NUM_BARS | Decoded base, 64 bits per BAR |
| bar_size | output | 64*NUM_BARS | Window size, 64 bits per BAR |

## Verification
The bench programs the bank in several configurations and runs the host sizing probe and base assignment against each one:
- A 4 KiB 32-bit window with and without the prefetch bit shows whether the attribute nibble survives host writes.
- A 16 GiB pair shows whether the masks are chained and whether the upper slot has no attributes.
- A zero-mask slot and a 64-bit type in the last slot exercise the disabled case and the partnerless case.
- Local writes with the enable low, and host accesses outside the slot range, must leave every output unchanged. This separates a correctly gated bank from one that leaks writes.

// File: rtl/bar_bank.sv
module bar_bank #(
  parameter int NUM_BARS = 6,
  parameter int AW       = 8,
  parameter int BASE_OFS = 'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          cfg_addr,
  input  logic                   cfg_wr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [AW-1:0]          loc_addr,
  input  logic                   loc_wr,
  input  logic                   loc_shadow,
  input  logic [31:0]            loc_wdata,
  input  logic                   ro_wr_en,
  output logic [NUM_BARS-1:0]    bar_valid,
  output logic [64*NUM_BARS-1:0] bar_base,
  output logic [64*NUM_BARS-1:0] bar_size
);
  localparam int FIRST = BASE_OFS / 4;
  localparam logic [31:0] ATTR_CLR = 32'hFFFF_FFF0;

  logic [31:0] addr_q [NUM_BARS];
  logic [3:0]  attr_q [NUM_BARS];
  logic [31:0] mask_q [NUM_BARS];
  logic [31:0] rd_val [NUM_BARS];
  logic [NUM_BARS-1:0] cfg_sel, loc_sel, is_up, en;

  wire [AW-3:0] cfg_dw = cfg_addr[AW-1:2];
  wire [AW-3:0] loc_dw = loc_addr[AW-1:2];

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
    logic [31:0] hi_m, hi_a, lo_a;
    logic        pair;
    logic [63:0] m64;

    assign cfg_sel[i] = (cfg_dw == (AW-2)'(FIRST + i));
    assign loc_sel[i] = (loc_dw == (AW-2)'(FIRST + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        attr_q[i] <= '0;
        mask_q[i] <= '0;
      end else begin
        if (cfg_wr && cfg_sel[i]) addr_q[i] <= cfg_wdata;
        if (ro_wr_en && loc_wr && loc_sel[i]) begin
          if (loc_shadow) mask_q[i] <= loc_wdata;
          else            attr_q[i] <= loc_wdata[3:0];
        end
      end
    end

    if (i == 0) begin : g_first
      assign is_up[i] = 1'b0;
    end else begin : g_rest
      assign is_up[i] = !is_up[i-1] && (attr_q[i-1][2:1] == 2'b10);
    end

    assign pair = !is_up[i] && (attr_q[i][2:1] == 2'b10) && (i < NUM_BARS - 1);

    if (i < NUM_BARS - 1) begin : g_hi
      assign hi_m = pair ? mask_q[i+1] : 32'h0;
      assign hi_a = pair ? (addr_q[i+1] & ~mask_q[i+1]) : 32'h0;
    end else begin : g_nohi
      assign hi_m = 32'h0;
      assign hi_a = 32'h0;
    end

    assign lo_a  = addr_q[i] & ~mask_q[i] & ATTR_CLR;
    assign m64   = {hi_m, mask_q[i]};
    assign en[i] = |m64;

    if (i == 0) begin : g_rd0
      assign rd_val[i] = en[i] ? (lo_a | {28'h0, attr_q[i]}) : 32'h0;
    end else begin : g_rdn
      assign rd_val[i] = is_up[i] ? (en[i-1] ? (addr_q[i] & ~mask_q[i]) : 32'h0)
                                  : (en[i] ? (lo_a | {28'h0, attr_q[i]}) : 32'h0);
    end

    assign bar_valid[i]         = en[i] && !is_up[i];
    assign bar_base[i*64 +: 64] = bar_valid[i] ? {hi_a, lo_a} : 64'h0;
    assign bar_size[i*64 +: 64] = bar_valid[i] ? (m64 + 64'd1) : 64'h0;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NUM_BARS; k++)
      if (cfg_sel[k]) cfg_rdata = cfg_rdata | rd_val[k];
  end
endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk #(
  parameter int NUM_BARS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr,
  input logic                   loc_wr,
  input logic                   ro_wr_en,
  input logic [NUM_BARS-1:0]    bar_valid,
  input logic [64*NUM_BARS-1:0] bar_base,
  input logic [64*NUM_BARS-1:0] bar_size
);
  AST_SIZE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_wr_en |=> $stable(bar_size)); // R3

  AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ro_wr_en |=> $stable(bar_valid)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !(loc_wr && ro_wr_en)) |=> ($stable(bar_base) && $stable(bar_valid))); // R11

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_al
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      bar_valid[i] |-> ((bar_base[i*64 +: 64] & (bar_size[i*64 +: 64] - 64'd1)) == 64'd0)); // R4
  end
endmodule

bind bar_bank bar_bank_chk #(.NUM_BARS(NUM_BARS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .loc_wr(loc_wr),
  .ro_wr_en(ro_wr_en), .bar_valid(bar_valid), .bar_base(bar_base),
  .bar_size(bar_size));

// File: tb/bar_bank_tb.sv
`timescale 1ns/100ps
module bar_bank_tb;
  localparam int N = 6;
  localparam int AW = 8;
  localparam int BOFS = 'h10;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cfg_addr = '0, loc_addr = '0;
  logic cfg_wr = 0, loc_wr = 0, loc_shadow = 0, ro_wr_en = 0;
  logic [31:0] cfg_wdata = '0, loc_wdata = '0, cfg_rdata;
  logic [N-1:0] bar_valid;
  logic [64*N-1:0] bar_base, bar_size;

  int n_run = 0, n_fail = 0;
  bit live = 0, done = 0;

  logic [31:0] m_addr [N];
  logic [3:0]  m_attr [N];
  logic [31:0] m_mask [N];

  always #2.5 clk = ~clk;

  bar_bank #(.NUM_BARS(N), .AW(AW), .BASE_OFS(BOFS)) u_dut (.*);

  function automatic bit m_up(int n);
    bit u = 0;
    for (int k = 1; k <= n; k++) u = !u && (m_attr[k-1][2:1] == 2'b10);
    return u;
  endfunction
  function automatic bit m_pair(int n);
    return !m_up(n) && m_attr[n][2:1] == 2'b10 && n < N-1;
  endfunction
  function automatic logic [63:0] m_m64(int n);
    return {m_pair(n) ? m_mask[n+1] : 32'h0, m_mask[n]};
  endfunction
  function automatic bit m_valid(int n);
    return !m_up(n) && m_m64(n) != 0;
  endfunction
  function automatic logic [63:0] m_base(int n);
    if (!m_valid(n)) return 0;
    return {m_pair(n) ? (m_addr[n+1] & ~m_mask[n+1]) : 32'h0,
            m_addr[n] & ~m_mask[n] & 32'hFFFF_FFF0};
  endfunction
  function automatic logic [63:0] m_size(int n);
    return m_valid(n) ? m_m64(n) + 64'd1 : 64'd0;
  endfunction
  function automatic logic [31:0] m_rd(logic [AW-1:0] a);
    int n = (int'(a) - BOFS) / 4;
    if (int'(a) < BOFS || n >= N) return 0;
    if (m_up(n)) return (m_m64(n-1) != 0) ? (m_addr[n] & ~m_mask[n]) : 32'h0;
    if (m_m64(n) == 0) return 0;
    return (m_addr[n] & ~m_mask[n] & 32'hFFFF_FFF0) | {28'h0, m_attr[n]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (live) begin
      chk("R10 rdata", {32'h0, cfg_rdata}, {32'h0, m_rd(cfg_addr)});
      for (int n = 0; n < N; n++) begin
        chk("R10 valid", {63'h0, bar_valid[n]}, {63'h0, m_valid(n)});
        chk("R10 base", bar_base[n*64 +: 64], m_base(n));
        chk("R10 size", bar_size[n*64 +: 64], m_size(n));
      end
    end
  end

  task automatic host_wr(logic [AW-1:0] a, logic [31:0] d);
    int n = (int'(a) - BOFS) / 4;
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
    @(posedge clk);
    if (int'(a) >= BOFS && n < N) m_addr[n] = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic loc_wr_t(int n, bit sh, logic [31:0] d);
    loc_addr = AW'(BOFS + 4*n); loc_shadow = sh; loc_wdata = d; loc_wr = 1;
    @(posedge clk);
    if (ro_wr_en) begin
      if (sh) m_mask[n] = d; else m_attr[n] = d[3:0];
    end
    @(negedge clk); loc_wr = 0;
  endtask

  task automatic host_rd(string tag, int n, logic [31:0] exp);
    cfg_addr = AW'(BOFS + 4*n);
    #1;
    chk(tag, {32'h0, cfg_rdata}, {32'h0, exp});
    @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < N; n++) begin m_addr[n] = 0; m_attr[n] = 0; m_mask[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    for (int n = 0; n < N; n++) host_rd("R1 reset read", n, 0);
    chk("R1 reset valid", {58'h0, bar_valid}, 64'h0);

    ro_wr_en = 0;
    loc_wr_t(0, 0, 32'h8);
    loc_wr_t(0, 1, 32'hFFF);
    host_wr(BOFS, 32'hFFFF_FFFF);
    host_rd("R2 locked attr", 0, 0);
    chk("R3 locked mask", bar_size[63:0], 64'h0);

    ro_wr_en = 1;
    loc_wr_t(0, 1, 32'h0000_0FFF);
    host_wr(BOFS, 32'hFFFF_FFFF);
    host_rd("R4 sizing 4K", 0, 32'hFFFF_F000);
    chk("R10 size 4K", bar_size[63:0], 64'h1000);
    loc_wr_t(0, 0, 32'h8);
    host_wr(BOFS, 32'h1234_5677);
    host_rd("R5 attr kept", 0, 32'h1234_5008);
    chk("R10 base 32", bar_base[63:0], 64'h1234_5000);

    loc_wr_t(2, 0, 32'hC);
    loc_wr_t(3, 0, 32'hF);
    loc_wr_t(2, 1, 32'hFFFF_FFFF);
    loc_wr_t(3, 1, 32'h3);
    host_wr(BOFS + 8, 32'hFFFF_FFFF);
    host_wr(BOFS + 12, 32'hFFFF_FFFF);
    host_rd("R8 lower probe", 2, 32'h0000_000C);
    host_rd("R8 upper probe", 3, 32'hFFFF_FFFC);
    chk("R8 size 16G", bar_size[2*64 +: 64], 64'h4_0000_0000);
    chk("R7 upper invalid", {63'h0, bar_valid[3]}, 64'h0);
    host_wr(BOFS + 12, 32'h0000_0004);
    host_wr(BOFS + 8, 32'h0);
    chk("R10 base 64", bar_base[2*64 +: 64], 64'h4_0000_0000);
    loc_wr_t(3, 0, 32'h4);
    host_rd("R7 upper no pair", 3, 32'h0000_0004);

    host_wr(BOFS + 16, 32'hFFFF_FFFF);
    host_rd("R6 disabled", 4, 0);
    chk("R6 disabled valid", {63'h0, bar_valid[4]}, 64'h0);

    loc_wr_t(5, 0, 32'h4);
    loc_wr_t(5, 1, 32'hFF);
    host_wr(BOFS + 20, 32'hFFFF_FFFF);
    host_rd("R9 last slot", 5, 32'hFFFF_FF04);
    chk("R9 size", bar_size[5*64 +: 64], 64'h100);
    chk("R9 base", bar_base[5*64 +: 64], 64'hFFFF_FF00);

    host_wr(8'h0C, 32'hFFFF_FFFF);
    host_wr(BOFS + 24, 32'hFFFF_FFFF);
    cfg_addr = BOFS + 24; #1;
    chk("R11 out of range", {32'h0, cfg_rdata}, 64'h0);
    @(negedge clk);
    host_rd("R11 slot0 untouched", 0, 32'h1234_5008);

    ro_wr_en = 0;
    loc_wr_t(0, 1, 32'h0);
    host_rd("R3 mask held", 0, 32'h1234_5008);
    host_wr(BOFS, 32'hABCD_EFFF);
    host_rd("R4 host while locked", 0, 32'hABCD_E008);

    repeat (2) @(negedge clk);
    live = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule